// File: doc/BRIEF.md
# Serial Interface Status and Bit Counter

This block holds the status and bit-counting logic of a serial port that runs either as a two-wire bus interface or as a three-wire clocked port. It watches the clock and data pin levels through synchronizers. From them it finds start and stop conditions and edges of the clock pin. It keeps a 4-bit counter that counts clocks taken from one of several sources, and it keeps sticky event flags. The shift register, the data register and the system interrupt controller live outside the block. The block receives only the shift register's top bit and the enable bits.

Software sees everything through one 8-bit status register. A write loads the counter and clears the flags whose bits are written as one. In two-wire mode the block asks for the clock line to be held low after a start condition or after a counter wrap. Each hold ends when software clears the flag that caused it. The block also produces two interrupt requests and a live data-collision indication.

Top module: `sif_status`

## Requirements
- R1: After reset every status bit reads 0, and `scl_hold_o`, `start_irq_o` and `ovf_irq_o` are 0.
- R2: Status layout: bit 7 start flag, bit 6 wrap flag, bit 5 stop flag, bit 4 collision, bits 3..0 counter. With `clk_sel_i`=2'b01 the counter adds one per `timer_ovf_i` pulse. With `clk_sel_i`=2'b00 it adds one per `soft_clk_stb_i` pulse. A source that is not selected has no effect.
- R3: A counter step from 15 to 0 sets the wrap flag (bit 6).
- R4: A write clears bit 7, 6 or 5 only where the written bit is 1. A 0 leaves the flag as it is, and writing bit 4 has no effect.
- R5: Any register write loads bits 3..0 of the written byte into the counter.
- R6: When a write and a counter clock fall in the same cycle, the written value is kept, and the wrap flag is not set by that clock.
- R7: In two-wire mode (`mode_i[1]`=1), a falling synchronized data level while the synchronized clock level is high sets the start flag. The flag is visible after the third rising clock edge that follows the pin change. A data fall while the clock pin is low sets nothing.
- R8: `start_irq_o` equals start flag AND `start_ie_i` AND `gie_i`. `ovf_irq_o` equals wrap flag AND `ovf_ie_i` AND `gie_i`.
- R9: `scl_hold_o` is 1 only in two-wire mode, while a start hold or a wrap hold is pending. A start condition in two-wire mode sets the start hold, and a counter wrap in two-wire mode sets the wrap hold. Each hold is released by clearing its own flag.
- R10: In two-wire mode, a rising data level while the clock level is high sets the stop flag (bit 5). The stop flag never raises an interrupt.
- R11: With `clk_sel_i[1]`=1 and `sw_clk_en_i`=0, every rising and falling edge of the synchronized clock pin steps the counter. Outside two-wire mode, each such edge also sets the start flag.
- R12: With `clk_sel_i[1]`=1 and `sw_clk_en_i`=1, clock-pin edges neither step the counter nor set the start flag, and each `toggle_stb_i` pulse steps the counter.
- R13: In two-wire mode, bit 4 and `collision_o` are 1 when `shift_msb_i` differs from the synchronized data level. In other modes they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 output disabled, 01 three-wire, 1x two-wire |
| clk_sel_i | input | 2 | Counter clock source select |
| sw_clk_en_i | input | 1 | Software clock bit; with an external source it routes the toggle strobe |
| soft_clk_stb_i | input | 1 | Software clock strobe (source 00) |
| toggle_stb_i | input | 1 | Toggle strobe (external source with software clock bit set) |
| timer_ovf_i | input | 1 | Timer overflow pulse (source 01) |
| scl_pin_i | input | 1 | Clock pin level, asynchronous |
| sda_pin_i | input | 1 | Data pin level, asynchronous |
| shift_msb_i | input | 1 | Top bit of the external shift register |
| start_ie_i | input | 1 | Start interrupt enable |
| ovf_ie_i | input | 1 | Wrap interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 8 | Status register write data |
| reg_rdata_o | output | 8 | Status register read value |
| start_irq_o | output | 1 | Start interrupt request |
| ovf_irq_o | output | 1 | Wrap interrupt request |
| collision_o | output | 1 | Data collision indication |
| scl_hold_o | output | 1 | Request to hold the clock line low |

## Verification
A software write and a counter clock can arrive in the same cycle. So can a flag clear and a new flag-setting event. The bench provokes the first case by raising the timer pulse together with a register write while the counter holds 15. It expects the written value to appear and the wrap flag to stay clear. On the next pulse alone it expects the count to continue from the written value. It also sweeps every counter value through loads and long runs of clocks, so the wrap boundary is exercised both by a clock and by a load.

// File: rtl/sif_pkg.sv
package sif_pkg;

    localparam int unsigned CNT_W  = 4;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned SYNC_N = 2;

    localparam int unsigned BIT_START = 7;
    localparam int unsigned BIT_OVF   = 6;
    localparam int unsigned BIT_STOP  = 5;
    localparam int unsigned BIT_COLL  = 4;

    typedef enum logic [1:0] {
        CS_SOFT   = 2'b00,
        CS_TIMER  = 2'b01,
        CS_PIN_A  = 2'b10,
        CS_PIN_B  = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic             start_f;
        logic             ovf_f;
        logic             stop_f;
        logic             start_hold;
        logic             ovf_hold;
        logic [CNT_W-1:0] cnt;
    } sif_state_t;

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int unsigned    W       = 2,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    logic [W-1:0] stage_q [STAGES+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i <= STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout  = stage_q[STAGES-1];
    assign dprev = stage_q[STAGES];
endmodule

// File: rtl/sif_cond_detect.sv
module sif_cond_detect (
    input  logic scl_s,
    input  logic scl_p,
    input  logic sda_s,
    input  logic sda_p,
    output logic start_cond,
    output logic stop_cond,
    output logic scl_edge
);
    logic scl_high;

    always_comb begin
        scl_high   = scl_s & scl_p;
        start_cond = scl_high & sda_p & ~sda_s;
        stop_cond  = scl_high & ~sda_p & sda_s;
        scl_edge   = scl_s ^ scl_p;
    end
endmodule

// File: rtl/sif_tick_sel.sv
module sif_tick_sel
    import sif_pkg::*;
(
    input  logic [1:0] clk_sel,
    input  logic       sw_clk_en,
    input  logic       scl_edge,
    input  logic       timer_ovf,
    input  logic       soft_stb,
    input  logic       toggle_stb,
    output logic       tick,
    output logic       pin_edge_evt
);
    always_comb begin
        tick         = 1'b0;
        pin_edge_evt = 1'b0;
        unique case (clk_sel_e'(clk_sel))
            CS_SOFT:  tick = soft_stb;
            CS_TIMER: tick = timer_ovf;
            CS_PIN_A,
            CS_PIN_B: begin
                if (sw_clk_en) begin
                    tick = toggle_stb;
                end else begin
                    tick         = scl_edge;
                    pin_edge_evt = scl_edge;
                end
            end
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/sif_status.sv
module sif_status
    import sif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       clk_sel_i,
    input  logic             sw_clk_en_i,
    input  logic             soft_clk_stb_i,
    input  logic             toggle_stb_i,
    input  logic             timer_ovf_i,
    input  logic             scl_pin_i,
    input  logic             sda_pin_i,
    input  logic             shift_msb_i,
    input  logic             start_ie_i,
    input  logic             ovf_ie_i,
    input  logic             gie_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             start_irq_o,
    output logic             ovf_irq_o,
    output logic             collision_o,
    output logic             scl_hold_o
);
    localparam sif_state_t ST_RESET = '0;

    logic [1:0] pin_s, pin_p;
    logic       start_cond, stop_cond, scl_edge;
    logic       tick, pin_edge_evt;
    logic       two_wire;
    logic [1:0] unused_bits;

    sif_state_t st_d, st_q;

    sif_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_pin_i, sda_pin_i}),
        .dout  (pin_s),
        .dprev (pin_p)
    );

    sif_cond_detect u_cond (
        .scl_s      (pin_s[1]),
        .scl_p      (pin_p[1]),
        .sda_s      (pin_s[0]),
        .sda_p      (pin_p[0]),
        .start_cond (start_cond),
        .stop_cond  (stop_cond),
        .scl_edge   (scl_edge)
    );

    sif_tick_sel u_tick (
        .clk_sel      (clk_sel_i),
        .sw_clk_en    (sw_clk_en_i),
        .scl_edge     (scl_edge),
        .timer_ovf    (timer_ovf_i),
        .soft_stb     (soft_clk_stb_i),
        .toggle_stb   (toggle_stb_i),
        .tick         (tick),
        .pin_edge_evt (pin_edge_evt)
    );

    assign two_wire    = mode_i[1];
    assign unused_bits = {mode_i[0], reg_wdata_i[BIT_COLL]};

    always_comb begin
        logic             clr_start, clr_ovf, clr_stop;
        logic             wrap;
        logic             start_set;
        logic [CNT_W:0]   sum;

        clr_start = reg_wr_i & reg_wdata_i[BIT_START];
        clr_ovf   = reg_wr_i & reg_wdata_i[BIT_OVF];
        clr_stop  = reg_wr_i & reg_wdata_i[BIT_STOP];

        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        wrap = 1'b0;

        if (reg_wr_i) begin
            st_d.cnt = reg_wdata_i[CNT_W-1:0];
        end else if (tick) begin
            st_d.cnt = sum[CNT_W-1:0];
            wrap     = sum[CNT_W];
        end

        start_set = two_wire ? start_cond : pin_edge_evt;

        st_d.start_f    = start_set | (st_q.start_f & ~clr_start);
        st_d.start_hold = (two_wire & start_cond) | (st_q.start_hold & ~clr_start);
        st_d.ovf_f      = wrap | (st_q.ovf_f & ~clr_ovf);
        st_d.ovf_hold   = (two_wire & wrap) | (st_q.ovf_hold & ~clr_ovf);
        st_d.stop_f     = (two_wire & stop_cond) | (st_q.stop_f & ~clr_stop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign collision_o = two_wire & (shift_msb_i ^ pin_s[0]);
    assign reg_rdata_o = {st_q.start_f, st_q.ovf_f, st_q.stop_f, collision_o, st_q.cnt};
    assign start_irq_o = st_q.start_f & start_ie_i & gie_i;
    assign ovf_irq_o   = st_q.ovf_f & ovf_ie_i & gie_i;
    assign scl_hold_o  = two_wire & (st_q.start_hold | st_q.ovf_hold);
endmodule

// File: rtl/sif_status_chk.sv
module sif_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       start_ie_i,
    input logic       ovf_ie_i,
    input logic       gie_i,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       start_irq_o,
    input logic       ovf_irq_o,
    input logic       scl_hold_o
);
    // R3: a freshly set wrap flag always comes with a counter at zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata_o[6]) |-> (reg_rdata_o[3:0] == 4'd0));

    // R4: flags stay set unless their own bit is written as one
    p_start_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[7] && !(reg_wr_i && reg_wdata_i[7])) |=> reg_rdata_o[7]);
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[6] && !(reg_wr_i && reg_wdata_i[6])) |=> reg_rdata_o[6]);
    p_ro_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_wdata_i[4] && mode_i == 2'b01) |-> !reg_rdata_o[4]);

    // R5, R6: a write always lands in the counter, clock or not
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> (reg_rdata_o[3:0] == $past(reg_wdata_i[3:0])));

    // R8: requests need flag and both enables
    p_start_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_irq_o |-> (reg_rdata_o[7] && start_ie_i && gie_i));
    p_ovf_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq_o |-> (reg_rdata_o[6] && ovf_ie_i && gie_i));

    // R9: hold only in two-wire mode
    p_hold_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold_o |-> mode_i[1]);

    // R10: stop flag is sticky until cleared
    p_stop_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[5] && !(reg_wr_i && reg_wdata_i[5])) |=> reg_rdata_o[5]);

    // R13: collision only reported in two-wire mode
    p_coll_mode_r13: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[4] |-> mode_i[1]);
endmodule

bind sif_status sif_status_chk u_chk (.*);

// File: tb/sif_status_bench.sv
module sif_status_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode, clk_sel;
    logic       sw_clk_en, soft_stb, toggle_stb, timer_ovf;
    logic       scl_pin, sda_pin, shift_msb;
    logic       start_ie, ovf_ie, gie;
    logic       reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       start_irq, ovf_irq, collision, scl_hold;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sif_status u_sif_status (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .clk_sel_i(clk_sel),
        .sw_clk_en_i(sw_clk_en), .soft_clk_stb_i(soft_stb), .toggle_stb_i(toggle_stb),
        .timer_ovf_i(timer_ovf), .scl_pin_i(scl_pin), .sda_pin_i(sda_pin),
        .shift_msb_i(shift_msb), .start_ie_i(start_ie), .ovf_ie_i(ovf_ie), .gie_i(gie),
        .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .start_irq_o(start_irq), .ovf_irq_o(ovf_irq), .collision_o(collision),
        .scl_hold_o(scl_hold)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // write flags byte with counter kept at the expected value
    task automatic wr_flags(input logic [7:0] hi);
        reg_wr = 1'b1;
        reg_wdata = {hi[7:4], exp_cnt[3:0]};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_cnt(input int v);
        reg_wr = 1'b1;
        reg_wdata = {4'h0, v[3:0]};
        exp_cnt = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; mode = 2'b00; clk_sel = 2'b01; sw_clk_en = 1'b0;
        soft_stb = 1'b0; toggle_stb = 1'b0; timer_ovf = 1'b0;
        scl_pin = 1'b1; sda_pin = 1'b1; shift_msb = 1'b0;
        start_ie = 1'b0; ovf_ie = 1'b0; gie = 1'b0;
        reg_wr = 1'b0; reg_wdata = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 status", reg_rdata, 0);
        check("R1 hold", scl_hold, 0);
        check("R1 irqs", {start_irq, ovf_irq}, 0);

        // R2/R3 timer-clocked sweep past one wrap
        for (int i = 1; i <= 20; i++) begin
            pulse(timer_ovf);
            exp_cnt = (exp_cnt + 1) % 16;
            check("R2 timer count", reg_rdata[3:0], exp_cnt);
            check("R3 wrap flag", reg_rdata[6], (i >= 16) ? 1 : 0);
        end
        check("R9 no hold outside two-wire", scl_hold, 0);

        // R2 unselected sources ignored
        pulse(soft_stb);
        pulse(toggle_stb);
        check("R2 unselected", reg_rdata[3:0], exp_cnt);

        // R4 write-one-to-clear
        wr_flags(8'h00);
        check("R4 zero keeps", reg_rdata[6], 1);
        wr_flags(8'h10);
        check("R4 bit4 ignored", reg_rdata[4], 0);
        check("R4 bit4 keeps wrap", reg_rdata[6], 1);

        // R8 wrap request gating
        for (int k = 0; k < 4; k++) begin
            ovf_ie = k[0]; gie = k[1];
            @(negedge clk);
            check("R8 wrap irq", ovf_irq, k[0] & k[1]);
        end
        wr_flags(8'h40);
        check("R4 clear wrap", reg_rdata[6], 0);
        check("R8 irq drops", ovf_irq, 0);

        // R5 load every value
        for (int v = 0; v < 16; v++) begin
            wr_cnt(v);
            check("R5 load", reg_rdata[3:0], v);
        end

        // R6 write and clock in one cycle at 15
        wr_cnt(15);
        reg_wr = 1'b1; reg_wdata = 8'h03; timer_ovf = 1'b1; exp_cnt = 3;
        @(negedge clk);
        reg_wr = 1'b0; timer_ovf = 1'b0;
        check("R6 write wins", reg_rdata[3:0], 3);
        check("R6 no wrap", reg_rdata[6], 0);
        pulse(timer_ovf);
        exp_cnt = 4;
        check("R6 continue", reg_rdata[3:0], 4);

        // R2 software strobe source
        clk_sel = 2'b00;
        pulse(soft_stb);
        exp_cnt++;
        check("R2 soft count", reg_rdata[3:0], exp_cnt);
        pulse(timer_ovf);
        check("R2 timer ignored", reg_rdata[3:0], exp_cnt);

        // R7 start condition in two-wire mode
        clk_sel = 2'b01; mode = 2'b10; start_ie = 1'b0; gie = 1'b0;
        sda_pin = 1'b0; settle();
        check("R7 start flag", reg_rdata[7], 1);
        check("R9 start hold", scl_hold, 1);
        check("R10 no stop", reg_rdata[5], 0);
        for (int k = 0; k < 4; k++) begin
            start_ie = k[0]; gie = k[1];
            @(negedge clk);
            check("R8 start irq", start_irq, k[0] & k[1]);
        end
        wr_flags(8'h80);
        check("R9 start release", scl_hold, 0);
        check("R7 cleared", reg_rdata[7], 0);

        // R10 stop condition, never an irq
        sda_pin = 1'b1; settle();
        check("R10 stop flag", reg_rdata[5], 1);
        ovf_ie = 1'b1;
        check("R10 no irq", {start_irq, ovf_irq}, 0);
        wr_flags(8'h20);
        check("R10 cleared", reg_rdata[5], 0);

        // R7 data fall with clock low sets nothing
        scl_pin = 1'b0; settle();
        sda_pin = 1'b0; settle();
        check("R7 clock low", reg_rdata[7], 0);
        sda_pin = 1'b1; settle();
        check("R10 clock low", reg_rdata[5], 0);

        // R13 collision sweep in two-wire mode
        for (int k = 0; k < 4; k++) begin
            shift_msb = k[0]; sda_pin = k[1]; settle();
            check("R13 collision bit", reg_rdata[4], k[0] ^ k[1]);
            check("R13 collision pin", collision, k[0] ^ k[1]);
        end
        shift_msb = 1'b1; sda_pin = 1'b0; settle();
        mode = 2'b01;
        @(negedge clk);
        check("R13 off outside two-wire", collision, 0);
        mode = 2'b10;
        sda_pin = 1'b1; shift_msb = 1'b0; settle();
        scl_pin = 1'b1; settle();

        // R9 wrap hold
        wr_cnt(15);
        pulse(timer_ovf);
        exp_cnt = 0;
        check("R9 wrap hold", scl_hold, 1);
        mode = 2'b01;
        @(negedge clk);
        check("R9 hold masked", scl_hold, 0);
        mode = 2'b10;
        @(negedge clk);
        check("R9 hold back", scl_hold, 1);
        wr_flags(8'h40);
        check("R9 wrap release", scl_hold, 0);

        // R11 pin edges, three-wire mode
        mode = 2'b01; start_ie = 1'b0; ovf_ie = 1'b0;
        for (int s = 2; s < 4; s++) begin
            clk_sel = s[1:0];
            for (int e = 0; e < 4; e++) begin
                scl_pin = ~scl_pin; settle();
                exp_cnt = (exp_cnt + 1) % 16;
                check("R11 edge count", reg_rdata[3:0], exp_cnt);
                check("R11 edge start", reg_rdata[7], 1);
                wr_flags(8'h80);
            end
        end

        // R11 in two-wire mode edges count but do not set start
        mode = 2'b10; clk_sel = 2'b10;
        scl_pin = ~scl_pin; settle();
        exp_cnt = (exp_cnt + 1) % 16;
        check("R11 two-wire count", reg_rdata[3:0], exp_cnt);
        check("R11 two-wire no start", reg_rdata[7], 0);

        // R12 software clock bit routes the toggle strobe
        mode = 2'b01; sw_clk_en = 1'b1;
        scl_pin = ~scl_pin; settle();
        check("R12 edge ignored", reg_rdata[3:0], exp_cnt);
        check("R12 no start", reg_rdata[7], 0);
        for (int t = 0; t < 3; t++) begin
            pulse(toggle_stb);
            exp_cnt = (exp_cnt + 1) % 16;
            check("R12 toggle count", reg_rdata[3:0], exp_cnt);
        end

        finish_run();
    end
endmodule